// File: doc/BRIEF.md
# Dual-Channel PWM Counter Slice

This block is one pulse-width modulation slice: a single up or up/down counter shared by two compare channels. The counter moves one step on each clock cycle in which the block is enabled and the external `tick_i` strobe is high. A separate divider produces that strobe, so the strobe rate and the top value together set the output period.

In edge mode the counter rises from 0 to the top value and then restarts at 0. In phase mode it rises to the top value and then falls back to 0. It spends two ticks at each endpoint, so the period is exactly twice the edge-mode period for the same top value. Each channel drives its output high while its compare value is greater than the counter. A compare value of 0 therefore gives a constant low level, and a compare value of top+1 gives a constant high level.

The top value, both compare values and the mode bit are held in shadow registers. Changes made mid-period are deferred to the next period boundary, so a partial or glitched pulse cannot occur. A one-cycle `wrap_o` pulse marks each period boundary.

Top module: `pwm_slice`

## Requirements
- R1: In edge mode the counter takes the values 0, 1, ..., top and then returns to 0, so one period is top+1 ticks and the counter never exceeds the active top.
- R2: In phase mode the counter follows 0, 1, ..., top, top, top-1, ..., 0, 0, 1, ... Each endpoint is held for two ticks, so one period is 2*(top+1) ticks. `phase_mode_i` = 1 selects phase mode and 0 selects edge mode.
- R3: While enabled, each channel output is 1 exactly when that channel's active compare value is greater than the current counter value.
- R4: A compare value of 0 keeps that channel's output at 0 for the whole period.
- R5: A compare value of top+1 keeps that channel's output at 1 for the whole period while enabled.
- R6: The counter changes only at clock edges where both `tick_i` and `en_i` are 1. At any other edge it keeps its value.
- R7: While `en_i` is 0, both outputs are 0, the counter holds its value, no wrap pulse is produced and `tick_i` is ignored. On re-enable the waveform resumes from the held position.
- R8: The inputs `top_i`, `cmp_a_i`, `cmp_b_i` and `phase_mode_i` are captured only at a period boundary, or while disabled with the counter at 0 and counting up. A change made mid-period first shows in the period that follows.
- R9: `wrap_o` is 1 for exactly the cycle after each tick that completes a period, and the counter reads 0 during that cycle.
- R10: After reset the counter is 0 and counting up, the active settings are zero in edge mode, and both outputs and `wrap_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Slice enable |
| phase_mode_i | input | 1 | 1 selects up/down phase mode, 0 selects edge mode |
| tick_i | input | 1 | Count strobe from the external divider |
| top_i | input | 16 | Requested top value |
| cmp_a_i | input | 16 | Requested compare value, channel A |
| cmp_b_i | input | 16 | Requested compare value, channel B |
| pwm_a_o | output | 1 | Channel A PWM level |
| pwm_b_o | output | 1 | Channel B PWM level |
| wrap_o | output | 1 | One-cycle period-boundary pulse |

## Verification
The hardest situation to reach from the ports is a configuration change that arrives in the middle of a period, especially one that also switches the mode. The shadow registers must then finish the old waveform and start the new one at exactly the boundary. The stimulus changes top, compares and mode a few ticks into a known period. The bench places the boundary arithmetically and checks both channels against the old settings before it and the new settings after it. Sparse strobe patterns and a disable window placed mid-period show that the counter holds its position and resumes from it.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_PHASE = 1'b1
  } pwm_mode_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_slice_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned NCH = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [W-1:0]            top_i,
  input  logic [NCH-1:0][W-1:0]   cmp_i,
  input  pwm_mode_e               mode_i,
  output logic [W-1:0]            top_o,
  output logic [NCH-1:0][W-1:0]   cmp_o,
  output pwm_mode_e               mode_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_o  <= '0;
      mode_o <= MODE_EDGE;
    end else if (load_i) begin
      top_o  <= top_i;
      mode_o <= mode_i;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cmp_o[ch] <= '0;
      else if (load_i) cmp_o[ch] <= cmp_i[ch];
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(top_o) && $stable(cmp_o) && $stable(mode_o))); // R8

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_slice_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  input  pwm_mode_e    mode_i,
  output logic [W-1:0] cnt_o,
  output logic         reload_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;
  logic         step, at_top, at_bot, period_end;

  assign step   = en_i & tick_i;
  assign at_top = (cnt_q == top_i);
  assign at_bot = (cnt_q == '0);

  // edge mode ends a period at top; phase mode ends it on the second tick at 0
  assign period_end = step & ((mode_i == MODE_EDGE) ? at_top : (down_q & at_bot));

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (step) begin
      if (mode_i == MODE_EDGE) begin
        cnt_d  = at_top ? '0 : cnt_q + ONE;
        down_d = 1'b0;
      end else if (!down_q) begin
        if (at_top) down_d = 1'b1;       // dwell one tick at top
        else        cnt_d  = cnt_q + ONE;
      end else begin
        if (at_bot) down_d = 1'b0;       // dwell one tick at bottom
        else        cnt_d  = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      wrap_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      wrap_o <= period_end;
    end
  end

  assign cnt_o    = cnt_q;
  // idle at bottom while disabled: safe point to take fresh settings
  assign reload_o = period_end | (~en_i & at_bot & ~down_q);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= top_i); // R1

  AST_EDGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && mode_i == MODE_EDGE && !at_top) |=> (cnt_q == $past(cnt_q) + ONE)); // R1

  AST_PHASE_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && mode_i == MODE_PHASE && !down_q && at_top) |=> (down_q && cnt_q == $past(cnt_q))); // R2

  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R6

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && !wrap_o)); // R7

  AST_WRAP_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (cnt_q == '0)); // R9

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned W = 16
) (
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  output logic         pwm_o
);

  assign pwm_o = en_i & (cmp_i > cnt_i);

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             phase_mode_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o,
  output logic             wrap_o
);

  localparam int unsigned NCH = NUM_CH;

  logic [NCH-1:0][CNT_W-1:0] cmp_req, cmp_act;
  logic [CNT_W-1:0]          top_act, cnt;
  pwm_mode_e                 mode_act;
  logic                      reload;
  logic [NCH-1:0]            pwm_vec;

  assign cmp_req[0] = cmp_a_i;
  assign cmp_req[1] = cmp_b_i;

  pwm_shadow #(.W(CNT_W), .NCH(NCH)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (reload),
    .top_i  (top_i),
    .cmp_i  (cmp_req),
    .mode_i (pwm_mode_e'(phase_mode_i)),
    .top_o  (top_act),
    .cmp_o  (cmp_act),
    .mode_o (mode_act)
  );

  pwm_counter #(.W(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick_i),
    .top_i    (top_act),
    .mode_i   (mode_act),
    .cnt_o    (cnt),
    .reload_o (reload),
    .wrap_o   (wrap_o)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_channel #(.W(CNT_W)) u_ch (
      .en_i  (en_i),
      .cnt_i (cnt),
      .cmp_i (cmp_act[ch]),
      .pwm_o (pwm_vec[ch])
    );
  end

  assign pwm_a_o = pwm_vec[0];
  assign pwm_b_o = pwm_vec[1];

endmodule

// File: tb/tb_pwm_slice.sv
`timescale 1ns/1ps
module tb_pwm_slice;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        phase_mode_i = 1'b0;
  logic        tick_i = 1'b0;
  logic [15:0] top_i = '0;
  logic [15:0] cmp_a_i = '0;
  logic [15:0] cmp_b_i = '0;
  logic        pwm_a_o, pwm_b_o, wrap_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pwm_slice dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .phase_mode_i(phase_mode_i),
    .tick_i(tick_i), .top_i(top_i), .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
    .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .wrap_o(wrap_o)
  );

  function automatic int period_of(int top, int m);
    return m ? 2 * (top + 1) : top + 1;
  endfunction

  function automatic int cval(int top, int m, int k);
    int r;
    r = k % period_of(top, m);
    if (!m) return r;
    return (r <= top) ? r : 2 * top + 1 - r;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // old settings, new settings applied when tick count reaches chg_k (-1: none)
  task automatic run_cfg(int top0, int ca0, int cb0, int m0,
                         int top1, int ca1, int cb1, int m1, int chg_k,
                         int ncyc, int tick_mod, int off_start, int off_len,
                         string tag);
    int k = 0;
    int b = 1 << 30;
    bit changed = 0;
    bit last_eff = 0;
    int p0, p1;
    p0 = period_of(top0, m0);
    p1 = period_of(top1, m1);
    if (chg_k > 0) b = (chg_k / p0 + 1) * p0;
    @(negedge clk);
    en_i = 0; tick_i = 0; rst_ni = 0;
    top_i = 16'(top0); cmp_a_i = 16'(ca0); cmp_b_i = 16'(cb0); phase_mode_i = m0[0];
    @(negedge clk);
    chk("R10", pwm_a_o, 1'b0);
    chk("R10", wrap_o, 1'b0);
    rst_ni = 1;
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < ncyc; c++) begin
      bit en_now, tk_now, exp_a, exp_b, exp_w;
      int t, a, bb, m, pos;
      string ra;
      en_now = !(c >= off_start && c < off_start + off_len);
      tk_now = (tick_mod == 0) ? 1'b1 : ((c % tick_mod) != tick_mod - 1);
      if (chg_k > 0 && !changed && k >= chg_k) begin
        changed = 1;
        top_i = 16'(top1); cmp_a_i = 16'(ca1); cmp_b_i = 16'(cb1); phase_mode_i = m1[0];
      end
      en_i = en_now; tick_i = tk_now;
      #1;
      if (k < b) begin t = top0; a = ca0; bb = cb0; m = m0; pos = k; end
      else       begin t = top1; a = ca1; bb = cb1; m = m1; pos = k - b; end
      exp_a = en_now && (a > cval(t, m, pos));
      exp_b = en_now && (bb > cval(t, m, pos));
      exp_w = last_eff && k > 0 && ((k <= b) ? (k % p0 == 0) : ((k - b) % p1 == 0));
      if (!en_now)         ra = "R7";
      else if (a == 0)     ra = "R4";
      else if (a == t + 1) ra = "R5";
      else                 ra = "R3";
      chk(ra, pwm_a_o, exp_a);
      chk(en_now ? tag : "R7", pwm_b_o, exp_b);
      chk("R9", wrap_o, exp_w);
      @(posedge clk);
      last_eff = en_now && tk_now;
      if (last_eff) k++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 / R2 sweeps: every compare value from 0 to top+1, both modes
    for (int m = 0; m < 2; m++)
      for (int t = 0; t <= 4; t++)
        for (int ca = 0; ca <= t + 1; ca++)
          run_cfg(t, ca, t + 1 - ca, m, t, ca, t + 1 - ca, m, -1,
                  2 * period_of(t, m) + 2, 0, -1, 0, m ? "R2" : "R1");
    // R6 sparse strobe
    run_cfg(3, 2, 3, 0, 3, 2, 3, 0, -1, 40, 3, -1, 0, "R6");
    run_cfg(3, 1, 3, 1, 3, 1, 3, 1, -1, 40, 3, -1, 0, "R6");
    // R7 disable window mid-period with strobe still active
    run_cfg(4, 3, 2, 0, 4, 3, 2, 0, -1, 24, 0, 7, 4, "R7");
    run_cfg(4, 3, 2, 1, 4, 3, 2, 1, -1, 30, 0, 6, 5, "R7");
    // R8 mid-period changes, including mode switches
    run_cfg(3, 2, 1, 0, 5, 4, 6, 0, 2, 30, 0, -1, 0, "R8");
    run_cfg(2, 1, 3, 0, 3, 2, 4, 1, 4, 30, 0, -1, 0, "R8");
    run_cfg(2, 1, 2, 1, 1, 2, 1, 0, 3, 24, 0, -1, 0, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule